// File: doc/BRIEF.md
# Automatic Sliding Door Controller

This block is the control logic for a motorised sliding door. It watches a bank of presence sensors, an obstruction sensor, a lock input and two end-of-travel switches. From these it issues two motor commands, one that drives the door open and one that drives it shut. It steps through four positions: shut, travelling open, held open and travelling shut. The position is held in a register. The motor commands are decoded combinationally from the present position and the current inputs, so a command drops in the same cycle that its limit switch closes.

Any active presence sensor counts as someone being present. While the door travels shut, a person or an obstruction makes it reverse at once. The lock keeps a shut door from opening. If the door is resting at the shut position but is not against its closed limit, the lock also pulls it fully shut. There is no data stream in this block, so every pin is a plain level signal sampled on the rising clock edge. Sensor debouncing, motor power and timers are handled outside the block.

Top module: `sliding_door_ctrl`

## Requirements
- R1: A synchronous, active-high reset puts the controller in the shut position. On the next cycle, with lock low and no presence, both drive outputs are 0.
- R2: Any one of the presence inputs being 1 counts as presence. Bit 0, bit 1 and bit 2 each have the same effect.
- R3: In the shut position the controller starts opening on the next edge only when lock is 0 and presence is 1. Otherwise it stays shut.
- R4: In the shut position with lock at 1, the close drive is 1 while the closed limit is 0, and 0 once the closed limit is 1.
- R5: While opening, the open drive is 1 exactly while the open limit is 0. An open limit of 1 moves the controller to held open on the next edge.
- R6: While held open, the controller stays held open as long as presence or obstruction is 1. When both are 0 it starts closing on the next edge. No drive is asserted while held open.
- R7: While closing, presence or obstruction moves the controller back to opening on the next edge, even if the closed limit is 1 in that same cycle. The close drive is 0 in that cycle.
- R8: While closing with no presence and no obstruction, a closed limit of 1 returns the controller to shut on the next edge. With the closed limit at 0, the close drive is 1 and the controller stays closing.
- R9: The open drive and the close drive are never 1 in the same cycle.
- R10: The lock has no effect on the opening, held-open and closing positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| presence_i | input | N_PRESENCE (3) | Presence sensors, any bit high means presence |
| obstruct_i | input | 1 | Obstruction sensor in the door path |
| lock_i | input | 1 | Lock request, keeps the door shut |
| at_open_i | input | 1 | Open end-of-travel switch |
| at_closed_i | input | 1 | Closed end-of-travel switch |
| drive_open_o | output | 1 | Motor command to move toward open |
| drive_close_o | output | 1 | Motor command to move toward shut |

## Verification
A fixed sequence of input vectors walks the controller through every arc of the state graph. Each vector carries the drive values expected in that cycle. The presence vector is varied so that each sensor bit alone triggers an opening, which separates a true OR from a test of a single bit. While closing, presence and obstruction are each applied separately, one of them together with the closed limit, to show that reversal takes priority over finishing the close. The lock is raised while the door is shut both off and against the closed limit, which separates the pull-shut drive from idling. The lock is also raised during opening and held open to show it has no effect there. A reset applied in the middle of an opening shows the return to the shut position.

// File: rtl/door_pkg.sv
package door_pkg;
  typedef enum logic [1:0] {
    ST_SHUT     = 2'b00,
    ST_OPENING  = 2'b01,
    ST_HELD     = 2'b11,
    ST_CLOSING  = 2'b10
  } door_state_e;
endpackage

// File: rtl/door_presence_merge.sv
module door_presence_merge #(
  parameter int N_PRESENCE = 3
) (
  input  logic [N_PRESENCE-1:0] sense_i,
  output logic                  anyone_o
);
  // Bit-serial OR chain so the merge width follows the parameter.
  logic [N_PRESENCE:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < N_PRESENCE; g++) begin : g_or
    assign chain[g+1] = chain[g] | sense_i[g];
  end
  assign anyone_o = chain[N_PRESENCE];
endmodule

// File: rtl/door_next_state.sv
module door_next_state
  import door_pkg::*;
(
  input  door_state_e cur_i,
  input  logic        anyone_i,
  input  logic        obstruct_i,
  input  logic        lock_i,
  input  logic        at_open_i,
  input  logic        at_closed_i,
  output door_state_e nxt_o
);
  always_comb begin
    unique case (cur_i)
      ST_SHUT:    nxt_o = (!lock_i && anyone_i) ? ST_OPENING : ST_SHUT;
      ST_OPENING: nxt_o = at_open_i ? ST_HELD : ST_OPENING;
      ST_HELD:    nxt_o = (anyone_i || obstruct_i) ? ST_HELD : ST_CLOSING;
      ST_CLOSING: begin
        // reversal wins over reaching the closed limit
        if (anyone_i || obstruct_i) nxt_o = ST_OPENING;
        else if (at_closed_i)       nxt_o = ST_SHUT;
        else                        nxt_o = ST_CLOSING;
      end
      default:    nxt_o = ST_SHUT;
    endcase
  end
endmodule

// File: rtl/door_drive_decode.sv
module door_drive_decode
  import door_pkg::*;
(
  input  door_state_e cur_i,
  input  logic        anyone_i,
  input  logic        obstruct_i,
  input  logic        lock_i,
  input  logic        at_open_i,
  input  logic        at_closed_i,
  output logic        open_o,
  output logic        close_o
);
  always_comb begin
    open_o  = 1'b0;
    close_o = 1'b0;
    unique case (cur_i)
      ST_SHUT:    close_o = lock_i && !at_closed_i;
      ST_OPENING: open_o  = !at_open_i;
      ST_HELD:    ;
      ST_CLOSING: close_o = !anyone_i && !obstruct_i && !at_closed_i;
      default:    ;
    endcase
  end
endmodule

// File: rtl/sliding_door_ctrl.sv
module sliding_door_ctrl
  import door_pkg::*;
#(
  parameter int N_PRESENCE = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_PRESENCE-1:0] presence_i,
  input  logic                  obstruct_i,
  input  logic                  lock_i,
  input  logic                  at_open_i,
  input  logic                  at_closed_i,
  output logic                  drive_open_o,
  output logic                  drive_close_o
);
  door_state_e state_q;
  door_state_e state_d;
  logic        anyone;

  door_presence_merge #(.N_PRESENCE(N_PRESENCE)) i_merge (
    .sense_i  (presence_i),
    .anyone_o (anyone)
  );

  door_next_state i_next (
    .cur_i       (state_q),
    .anyone_i    (anyone),
    .obstruct_i  (obstruct_i),
    .lock_i      (lock_i),
    .at_open_i   (at_open_i),
    .at_closed_i (at_closed_i),
    .nxt_o       (state_d)
  );

  door_drive_decode i_drive (
    .cur_i       (state_q),
    .anyone_i    (anyone),
    .obstruct_i  (obstruct_i),
    .lock_i      (lock_i),
    .at_open_i   (at_open_i),
    .at_closed_i (at_closed_i),
    .open_o      (drive_open_o),
    .close_o     (drive_close_o)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_SHUT;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/door_ctrl_checker.sv
module door_ctrl_checker #(
  parameter int N_PRESENCE = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic [N_PRESENCE-1:0] presence_i,
  input logic                  obstruct_i,
  input logic                  at_open_i,
  input logic                  at_closed_i,
  input logic                  drive_open_o,
  input logic                  drive_close_o,
  input logic [1:0]            state_q
);
  localparam logic [1:0] S_SHUT    = 2'b00;
  localparam logic [1:0] S_OPENING = 2'b01;
  localparam logic [1:0] S_HELD    = 2'b11;
  localparam logic [1:0] S_CLOSING = 2'b10;

  logic seen_any;
  assign seen_any = (presence_i != '0);

  // R1
  a_r1_reset_shut: assert property (@(posedge clk)
    rst |=> state_q == S_SHUT);

  // R9
  a_r9_drives_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(drive_open_o && drive_close_o));

  // R5
  a_r5_open_limit_stops: assert property (@(posedge clk) disable iff (rst)
    at_open_i |-> !drive_open_o);

  // R5
  a_r5_open_limit_advances: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_OPENING && at_open_i) |=> state_q == S_HELD);

  // R4, R8
  a_r8_closed_limit_stops: assert property (@(posedge clk) disable iff (rst)
    at_closed_i |-> !drive_close_o);

  // R7
  a_r7_reverse: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_CLOSING && (seen_any || obstruct_i)) |=> state_q == S_OPENING);

  // R6
  a_r6_held_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_HELD) |-> (!drive_open_o && !drive_close_o));
endmodule

bind sliding_door_ctrl door_ctrl_checker #(.N_PRESENCE(N_PRESENCE)) i_door_chk (
  .clk           (clk),
  .rst           (rst),
  .presence_i    (presence_i),
  .obstruct_i    (obstruct_i),
  .at_open_i     (at_open_i),
  .at_closed_i   (at_closed_i),
  .drive_open_o  (drive_open_o),
  .drive_close_o (drive_close_o),
  .state_q       (state_q)
);

// File: tb/test_sliding_door_ctrl.sv
module test_sliding_door_ctrl;
  localparam int NP = 3;
  localparam int NV = 25;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0] presence;
  logic          obstruct, lock, at_open, at_closed;
  logic          d_open, d_close;
  int            checks = 0;
  int            failures = 0;
  bit            done = 0;

  always #4 clk = ~clk;

  sliding_door_ctrl #(.N_PRESENCE(NP)) i_sliding_door_ctrl (
    .clk           (clk),
    .rst           (rst),
    .presence_i    (presence),
    .obstruct_i    (obstruct),
    .lock_i        (lock),
    .at_open_i     (at_open),
    .at_closed_i   (at_closed),
    .drive_open_o  (d_open),
    .drive_close_o (d_close)
  );

  // {presence[2:0], obstruct, lock, at_open, at_closed, exp_open, exp_close}
  localparam logic [8:0] VEC [NV] = '{
    9'b000_00_00_00, // 0  shut idle                      R3
    9'b001_01_00_01, // 1  lock, off limit: pull shut      R4
    9'b010_01_01_00, // 2  lock at limit: idle, stays      R4
    9'b100_00_01_00, // 3  presence bit2 -> opening        R2
    9'b000_00_00_10, // 4  opening drive                   R5
    9'b000_00_10_00, // 5  open limit -> held              R5
    9'b001_00_10_00, // 6  held by presence                R6
    9'b000_10_10_00, // 7  held by obstruction             R6
    9'b000_00_10_00, // 8  clear -> closing                R6
    9'b000_00_00_01, // 9  closing drive                   R8
    9'b010_00_00_00, // 10 presence reverses               R7
    9'b000_00_00_10, // 11 opening again                   R7
    9'b000_00_10_00, // 12 -> held                         R5
    9'b000_00_10_00, // 13 -> closing                      R6
    9'b000_10_00_00, // 14 obstruction reverses            R7
    9'b000_01_10_00, // 15 lock while opening, -> held     R10
    9'b000_01_10_00, // 16 lock while held, -> closing     R10
    9'b000_00_01_00, // 17 closed limit -> shut            R8
    9'b000_00_01_00, // 18 shut, no presence stays         R3
    9'b001_00_01_00, // 19 presence bit0 -> opening        R2
    9'b000_00_00_10, // 20 opening drive                   R5
    9'b000_00_10_00, // 21 -> held                         R5
    9'b000_00_10_00, // 22 -> closing                      R6
    9'b001_00_01_00, // 23 presence wins over closed limit R7
    9'b000_00_00_10  // 24 confirms opening                R7
  };

  function automatic string tag_of(int i);
    case (i)
      0, 18:              return "R3";
      1, 2:               return "R4";
      3, 19:              return "R2";
      4, 5, 12, 20, 21:   return "R5";
      6, 7, 8, 13, 22:    return "R6";
      9, 17:              return "R8";
      15, 16:             return "R10";
      default:            return "R7";
    endcase
  endfunction

  task automatic drive(input logic [NP-1:0] p, input logic ob, lk, ao, ac);
    presence = p; obstruct = ob; lock = lk; at_open = ao; at_closed = ac;
  endtask

  task automatic chk(input string req, input logic eo, input logic ec);
    checks++;
    if (d_open !== eo || d_close !== ec) begin
      failures++;
      $display("FAIL %s open=%0b close=%0b expected open=%0b close=%0b",
               req, d_open, d_close, eo, ec);
    end
    // R9: never both drives
    checks++;
    if (d_open === 1'b1 && d_close === 1'b1) begin
      failures++;
      $display("FAIL R9 open=%0b close=%0b expected not both", d_open, d_close);
    end
  endtask

  initial begin
    rst = 1'b1;
    drive('0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state is shut, quiet
    #1 chk("R1", 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][8:6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      #1 chk(tag_of(i), VEC[i][1], VEC[i][0]);
    end

    // R1: reset in the middle of opening returns to shut
    @(negedge clk);
    drive('0, 0, 0, 0, 0);
    #1 chk("R5", 1'b1, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1 chk("R1", 1'b0, 1'b0);
    // shut after reset: lock off-limit pulls shut
    drive('0, 0, 1, 0, 0);
    #1 chk("R4", 1'b0, 1'b1);
    // R3: presence with lock held keeps the door shut
    drive(3'b010, 0, 1, 0, 1);
    @(negedge clk);
    drive('0, 0, 0, 0, 0);
    #1 chk("R3", 1'b0, 1'b0);
    // R2: presence bit1 alone opens
    drive(3'b010, 0, 0, 0, 1);
    @(negedge clk);
    drive('0, 0, 0, 0, 0);
    #1 chk("R2", 1'b1, 1'b0);

    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog run=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule